// File: doc/BRIEF.md
# Address Sequence Command Decoder

This block watches the access stream of an asynchronous SRAM interface and recognises command sequences that are built only from read accesses to fixed addresses. A host can issue non-volatile commands (store, recall, auto-store on and off, and read-out of the last written address) over a plain SRAM bus. No extra pins are needed, and compatibility with an ordinary SRAM is kept.

Each access is sampled once, in the clock cycle where chip enable is seen going low. Five fixed reads form a common prefix. The sixth read selects one of seven commands. The block then emits a one-clock, one-hot pulse on its command output, and a separate unit carries out the command. A write, or a read to an address that does not match, abandons the sequence. While the chip is busy with a non-volatile transfer or is locked out by a power failure, no sequence can make progress.

Top module: `addr_seq_cmd_decoder`

## Requirements
- R1: An access is taken only in the clock cycle where `ce_n_i` is sampled low after being sampled high. This gives one access per low-going edge, whatever the address does while chip enable stays low. If `ce_n_i` is already low when reset is released, that is not an access until chip enable goes high and then low again.
- R2: The prefix is five reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order. Only these five reads, in this order, arm the sixth-step decode.
- R3: A sixth read after a complete prefix drives one bit of `cmd_o`: 0x8FC0 sets bit 0 (store), 0x4C63 sets bit 1 (recall), 0x8B45 sets bit 2 (auto-store off) and 0x4B46 sets bit 3 (auto-store on).
- R4: A sixth read of 0x0D30 sets bit 4 (address high byte), 0x4D30 sets bit 5 (middle byte) and 0x2D30 sets bit 6 (low byte). Three complete sequences run back to back yield the three byte pulses in turn.
- R5: `cmd_o` is zero or one-hot. It is high for exactly one clock, in the cycle that follows the clock edge at which the sixth access was sampled.
- R6: An access with `we_n_i` low returns the sequence to idle. A write to a command address at the sixth step produces no pulse.
- R7: A read that does not match the expected address returns the sequence to idle. If that read is to 0x4E38, the sequence restarts with step 2 as the next expected read.
- R8: After the sixth access the sequence is idle again, whether or not the address was a command.
- R9: While `busy_i` is high, accesses are ignored and the sequence is held idle. If `busy_i` is high in the same cycle as a valid sixth read, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low, synchronous to clk_i |
| we_n_i | input | 1 | Write enable, active low, sampled with the access |
| addr_i | input | 16 | Low address bits compared by the decoder |
| busy_i | input | 1 | Non-volatile transfer in progress or power-fail lockout |
| cmd_o | output | 7 | One-hot command pulse: 0 store, 1 recall, 2 auto-store off, 3 auto-store on, 4/5/6 address byte high/middle/low |

## Verification
A valid sixth read and a rising `busy_i` can land in the same cycle. The command decode and the busy hold-off then compete for that cycle. The bench provokes this by raising `busy_i` at the same falling clock edge at which it drives the sixth command read. It expects `cmd_o` to stay zero in the following cycle. It then runs a full sequence again with `busy_i` low, and expects that sequence to work, which confirms that the collision left no state behind. A second collision, between the abort of a sequence and a restart on the first prefix address in the same access, is judged by a sequence that then completes.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int ADDR_W     = 16;
  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMD    = 7;

  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      4:       return 16'h703F;
      default: return 16'h0000;
    endcase
  endfunction

  // index equals cmd_o bit position
  function automatic logic [ADDR_W-1:0] cmd_addr(input int idx);
    case (idx)
      0:       return 16'h8FC0;
      1:       return 16'h4C63;
      2:       return 16'h8B45;
      3:       return 16'h4B46;
      4:       return 16'h0D30;
      5:       return 16'h4D30;
      6:       return 16'h2D30;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/asc_ce_edge.sv
module asc_ce_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  output logic fall_o
);
  logic ce_n_q;

  // reset to low: a chip enable held low out of reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_n_q <= 1'b0;
    else         ce_n_q <= ce_n_i;
  end

  assign fall_o = ce_n_q & ~ce_n_i;
endmodule

// File: rtl/asc_seq_track.sv
module asc_seq_track #(
  parameter int CMP_W      = asc_pkg::ADDR_W,
  parameter int PREFIX_LEN = asc_pkg::PREFIX_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             access_i,
  input  logic             read_i,
  input  logic             busy_i,
  input  logic [CMP_W-1:0] addr_i,
  output logic             done_o
);
  localparam int ST_W = $clog2(PREFIX_LEN + 1);

  logic [ST_W-1:0]     st_q, st_d;
  logic [PREFIX_LEN:0] match;

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_match
    assign match[i] = (addr_i == asc_pkg::prefix_addr(i));
  end
  assign match[PREFIX_LEN] = 1'b0;

  always_comb begin
    st_d = st_q;
    if (busy_i) begin
      st_d = '0;
    end else if (access_i) begin
      if (!read_i)             st_d = '0;
      else if (match[st_q])    st_d = st_q + 1'b1;
      else if (match[0])       st_d = ST_W'(1);
      else                     st_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign done_o = (st_q == ST_W'(PREFIX_LEN));
endmodule

// File: rtl/asc_cmd_dec.sv
module asc_cmd_dec #(
  parameter int CMP_W   = asc_pkg::ADDR_W,
  parameter int NUM_CMD = asc_pkg::NUM_CMD
) (
  input  logic [CMP_W-1:0]   addr_i,
  output logic [NUM_CMD-1:0] hit_o
);
  for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
    assign hit_o[c] = (addr_i == asc_pkg::cmd_addr(c));
  end
endmodule

// File: rtl/addr_seq_cmd_decoder.sv
module addr_seq_cmd_decoder #(
  parameter int CMP_W   = asc_pkg::ADDR_W,
  parameter int NUM_CMD = asc_pkg::NUM_CMD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_n_i,
  input  logic               we_n_i,
  input  logic [CMP_W-1:0]   addr_i,
  input  logic               busy_i,
  output logic [NUM_CMD-1:0] cmd_o
);
  logic               ce_fall, access, done;
  logic [NUM_CMD-1:0] hit, cmd_d, cmd_q;

  asc_ce_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_n_i (ce_n_i),
    .fall_o (ce_fall)
  );

  assign access = ce_fall & ~busy_i;

  asc_seq_track #(.CMP_W(CMP_W), .PREFIX_LEN(asc_pkg::PREFIX_LEN)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (access),
    .read_i   (we_n_i),
    .busy_i   (busy_i),
    .addr_i   (addr_i),
    .done_o   (done)
  );

  asc_cmd_dec #(.CMP_W(CMP_W), .NUM_CMD(NUM_CMD)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign cmd_d = (access && we_n_i && done) ? hit : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/asc_chk.sv
module asc_chk #(
  parameter int NUM_CMD = asc_pkg::NUM_CMD
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ce_n_i,
  input logic               we_n_i,
  input logic               busy_i,
  input logic [NUM_CMD-1:0] cmd_o
);
  // R5
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));

  // R5
  cmd_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_o) |=> (cmd_o == '0));

  // R1
  cmd_needs_ce_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_o) |-> (!$past(ce_n_i) && $past(ce_n_i, 2)));

  // R6
  cmd_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_o) |-> $past(we_n_i));

  // R9
  busy_blocks_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cmd_o == '0));
endmodule

bind addr_seq_cmd_decoder asc_chk #(.NUM_CMD(NUM_CMD)) u_chk (.*);

// File: tb/addr_seq_cmd_decoder_tb.sv
`timescale 1ns/1ps
module addr_seq_cmd_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_n_i = 1'b0;
  logic        we_n_i = 1'b1;
  logic [15:0] addr_i = 16'h0;
  logic        busy_i = 1'b0;
  logic [6:0]  cmd_o;

  addr_seq_cmd_decoder u_dut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int         due;
    logic [6:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  localparam logic [15:0] P0 = 16'h4E38, P1 = 16'hB1C7, P2 = 16'h83E0,
                          P3 = 16'h7C1F, P4 = 16'h703F;
  localparam logic [15:0] A_ST = 16'h8FC0, A_RC = 16'h4C63, A_OFF = 16'h8B45,
                          A_ON = 16'h4B46, A_HI = 16'h0D30, A_MD = 16'h4D30,
                          A_LO = 16'h2D30;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (cmd_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: cmd_o=%b expected %b", it.req, cmd_o, it.exp);
        end
      end else if (cmd_o !== 7'b0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R5: unexpected cmd_o=%b expected 0000000", cmd_o);
      end
    end
  end

  task automatic acc(input logic [15:0] a, input bit wr, input logic [6:0] exp,
                     input string req, input bit bsy = 0);
    item_t it;
    @(negedge clk_i);
    ce_n_i = 1'b0; we_n_i = ~wr; addr_i = a; busy_i = bsy;
    it.due = cyc + 1; it.exp = exp; it.req = req;
    q.push_back(it);
    @(negedge clk_i);
    ce_n_i = 1'b1; we_n_i = 1'b1; busy_i = 1'b0;
  endtask

  task automatic prefix(input string req);
    acc(P0, 0, 0, req); acc(P1, 0, 0, req); acc(P2, 0, 0, req);
    acc(P3, 0, 0, req); acc(P4, 0, 0, req);
  endtask

  task automatic full(input logic [15:0] a, input logic [6:0] exp, input string req);
    prefix(req);
    acc(a, 0, exp, req);
  endtask

  initial begin
    // R1: ce low out of reset with first prefix address
    addr_i = P0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if (cmd_o !== 7'b0) begin
      n_fail++;
      $display("FAIL R5: reset cmd_o=%b expected 0000000", cmd_o);
    end
    ce_n_i = 1'b1;
    acc(P1, 0, 0, "R1"); acc(P2, 0, 0, "R1"); acc(P3, 0, 0, "R1");
    acc(P4, 0, 0, "R1"); acc(A_ST, 0, 0, "R1");

    // R3 and R4: every command
    full(A_ST,  7'b0000001, "R3");
    full(A_RC,  7'b0000010, "R3");
    full(A_OFF, 7'b0000100, "R3");
    full(A_ON,  7'b0001000, "R3");
    full(A_HI,  7'b0010000, "R4");
    full(A_MD,  7'b0100000, "R4");
    full(A_LO,  7'b1000000, "R4");

    // R6: write mid-sequence, then the remaining steps
    acc(P0, 0, 0, "R6"); acc(P1, 0, 0, "R6"); acc(P2, 1, 0, "R6");
    acc(P3, 0, 0, "R6"); acc(P4, 0, 0, "R6"); acc(A_ST, 0, 0, "R6");
    // R6: write to command address at sixth step
    prefix("R6"); acc(A_RC, 1, 0, "R6");
    full(A_RC, 7'b0000010, "R6");

    // R7: mismatch at step 4
    acc(P0, 0, 0, "R7"); acc(P1, 0, 0, "R7"); acc(P2, 0, 0, "R7");
    acc(16'h1234, 0, 0, "R7"); acc(P4, 0, 0, "R7"); acc(A_ON, 0, 0, "R7");
    // R7: restart on first prefix address
    acc(P0, 0, 0, "R7"); acc(P1, 0, 0, "R7");
    full(A_OFF, 7'b0000100, "R7");
    // R2: out-of-order prefix
    acc(P0, 0, 0, "R2"); acc(P2, 0, 0, "R2"); acc(P1, 0, 0, "R2");
    acc(P3, 0, 0, "R2"); acc(P4, 0, 0, "R2"); acc(A_ST, 0, 0, "R2");

    // R8: non-command sixth address, then idle
    full(16'h5555, 0, "R8");
    acc(P1, 0, 0, "R8"); acc(P2, 0, 0, "R8"); acc(P3, 0, 0, "R8");
    acc(P4, 0, 0, "R8"); acc(A_ST, 0, 0, "R8");
    // R8: command address straight after a command is not a repeat
    full(A_HI, 7'b0010000, "R8");
    acc(A_HI, 0, 0, "R8");

    // R9: busy mid-sequence
    acc(P0, 0, 0, "R9"); acc(P1, 0, 0, "R9"); acc(P2, 0, 0, "R9", 1);
    acc(P3, 0, 0, "R9"); acc(P4, 0, 0, "R9"); acc(A_ST, 0, 0, "R9");
    // R9: busy coincident with sixth read
    prefix("R9"); acc(A_ST, 0, 0, "R9", 1);
    full(A_ST, 7'b0000001, "R9");

    // R1: address change while ce stays low is not a new access
    acc(P0, 0, 0, "R1");
    @(negedge clk_i); ce_n_i = 1'b0; addr_i = P1;
    @(negedge clk_i); addr_i = P2;
    @(negedge clk_i); ce_n_i = 1'b1;
    acc(P3, 0, 0, "R1"); acc(P4, 0, 0, "R1"); acc(A_LO, 0, 0, "R1");

    // R4: full three-byte read-out back to back
    full(A_HI, 7'b0010000, "R4");
    full(A_MD, 7'b0100000, "R4");
    full(A_LO, 7'b1000000, "R4");

    repeat (4) @(negedge clk_i);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R5: %0d expected pulses unchecked, expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule